// File: doc/BRIEF.md
# Serial Display Command Receiver

This block sits behind a three-wire serial link (strobe, shift clock, data) that a host uses to set up a multiplexed LED display controller. All three serial lines are brought into the system clock domain through synchronizer stages. Edges of the shift clock are detected there, and bits are shifted in least significant bit first while the strobe is low. Each group of eight bits forms a byte. The strobe rising discards any partial byte.

The first byte of each strobe frame is a command. Its two top bits pick one of four register classes: grid/segment mode, data-path setup, RAM address, or display on/off with dimming. Every later byte in the same frame is display data. A data byte goes out on a one-cycle write port to a 14-byte display RAM, at the current address. The address then steps forward by one or stays where it is, depending on the data-path setup. An address outside the RAM blocks all data writes until a valid address is loaded again.

Top module: `segrx_top`

## Requirements
- R1: A data bit is taken on each rising edge of the serial clock while the strobe is low, least significant bit first. Serial clock edges while the strobe is high have no effect.
- R2: The first complete byte after the strobe falls is a command. A strobe rise partway through a byte discards the partial bits, and the next frame again starts with a command.
- R3: A command's bits 7:6 pick its class: 00 grid mode, 01 data setup, 11 address, 10 display control.
- R4: A grid mode command loads bits 1:0 into `disp_mode` and clears `disp_on`. If bits 1:0 equal the current mode, nothing changes, and `disp_on` keeps its value.
- R5: A data setup command loads `test_mode` from bit 3, `fixed_addr` from bit 2 and `wr_sel` from bits 1:0. Bits 5:4 are ignored.
- R6: An address command loads bits 3:0 into `cur_addr`. Bits 5:4 are ignored.
- R7: A display control command loads `dim_code` from bits 2:0 and `disp_on` from bit 3.
- R8: After reset: `disp_mode`=11, `test_mode`=0, `fixed_addr`=0, `wr_sel`=00, `cur_addr`=0, `disp_on`=0, `dim_code`=000, `ram_we`=0.
- R9: A data byte is written when `wr_sel`=00 and `cur_addr` is 0x00 to 0x0D. `ram_we` is high for one cycle, with `ram_addr`=`cur_addr` and `ram_wdata` equal to the byte. Register outputs and the write appear on the fourth system clock edge after the serial clock edge that completes the byte.
- R10: After a write, `cur_addr` advances by one when `fixed_addr`=0 and stays unchanged when `fixed_addr`=1.
- R11: While `cur_addr` is 0x0E or 0x0F, data bytes cause no write and leave `cur_addr` unchanged. With auto-increment, a write at 0x0D moves `cur_addr` to 0x0E, and later data bytes are dropped.
- R12: When `wr_sel` is not 00, data bytes cause no write and leave `cur_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_stb | input | 1 | Serial frame strobe, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data |
| disp_mode | output | 2 | Grid/segment mode |
| test_mode | output | 1 | Test mode flag |
| fixed_addr | output | 1 | 1 = address held after writes |
| wr_sel | output | 2 | Data destination select, 00 = display RAM |
| cur_addr | output | 4 | Current RAM address |
| disp_on | output | 1 | Display enabled |
| dim_code | output | 3 | Dimming step |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | 4 | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
A RAM write and an address update happen on the same edge. In increment mode this edge can also carry the address past the top of the RAM. The bench streams data bytes starting at 0x0C, so the write at 0x0D and the step to 0x0E land together, and the following byte must then produce no write. A behavioural model checks `ram_we`, `ram_addr`, `ram_wdata` and `cur_addr` against its own prediction on every clock. The same cycle-by-cycle comparison covers a mode change, which clears the display-on flag on the same edge that loads the new mode.

// File: rtl/segrx_pkg.sv
package segrx_pkg;

    localparam int BYTE_W    = 8;
    localparam int RAM_BYTES = 14;
    localparam int ADDR_W    = 4;
    localparam int CNT_W     = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        CLS_MODE = 2'b00,
        CLS_DATA = 2'b01,
        CLS_CTRL = 2'b10,
        CLS_ADDR = 2'b11
    } cmd_class_e;

    typedef struct packed {
        logic       test_mode;
        logic       fixed_addr;
        logic [1:0] wr_sel;
    } data_cfg_t;

    typedef struct packed {
        logic       on;
        logic [2:0] dim;
    } disp_ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              first;
    } rx_byte_t;

    localparam logic [1:0] MODE_RST = 2'b11;
    localparam logic [1:0] WSEL_RAM = 2'b00;

    function automatic cmd_class_e class_of(input logic [BYTE_W-1:0] b);
        return cmd_class_e'(b[7:6]);
    endfunction

    function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
        return (32'(a) < RAM_BYTES);
    endfunction

endpackage

// File: rtl/segrx_sync.sv
module segrx_sync #(
    parameter int             STAGES  = 2,
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] rise
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] pipe [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= async_in;
            for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign sync_out = pipe[LAST];
    assign rise     = pipe[LAST] & ~pipe[STAGES];

endmodule

// File: rtl/segrx_shift.sv
module segrx_shift
    import segrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stb_hi,
    input  logic     sclk_rise,
    input  logic     din,
    output rx_byte_t rx_byte,
    output logic     rx_vld
);
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              first_pend;
    logic [BYTE_W-1:0] next_shreg;

    assign next_shreg = {din, shreg[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        rx_vld <= 1'b0;
        if (rst) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            first_pend <= 1'b1;
            rx_byte    <= '0;
        end else if (stb_hi) begin
            bit_cnt    <= '0;
            first_pend <= 1'b1;
        end else if (sclk_rise) begin
            shreg <= next_shreg;
            if (32'(bit_cnt) == BYTE_W - 1) begin
                bit_cnt       <= '0;
                rx_vld        <= 1'b1;
                rx_byte.data  <= next_shreg;
                rx_byte.first <= first_pend;
                first_pend    <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    AST_IDLE_CNT: assert property (@(posedge clk) disable iff (rst)
        stb_hi |=> (bit_cnt == '0)); // R2
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_vld |=> !rx_vld); // R1
    AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (rst)
        stb_hi |=> first_pend); // R2

endmodule

// File: rtl/segrx_decode.sv
module segrx_decode
    import segrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_vld,
    input  rx_byte_t          rx_byte,
    output logic [1:0]        disp_mode,
    output data_cfg_t         dcfg,
    output logic [ADDR_W-1:0] cur_addr,
    output disp_ctrl_t        dctl,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata
);
    logic [BYTE_W-1:0] b;
    logic              write_ok;

    assign b        = rx_byte.data;
    assign write_ok = (dcfg.wr_sel == WSEL_RAM) && addr_ok(cur_addr);

    always_ff @(posedge clk) begin
        ram_we <= 1'b0;
        if (rst) begin
            disp_mode <= MODE_RST;
            dcfg      <= '0;
            cur_addr  <= '0;
            dctl      <= '0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else if (rx_vld) begin
            if (rx_byte.first) begin
                unique case (class_of(b))
                    CLS_MODE: begin
                        if (b[1:0] != disp_mode) begin
                            disp_mode <= b[1:0];
                            dctl.on   <= 1'b0;
                        end
                    end
                    CLS_DATA: begin
                        dcfg.test_mode  <= b[3];
                        dcfg.fixed_addr <= b[2];
                        dcfg.wr_sel     <= b[1:0];
                    end
                    CLS_ADDR: cur_addr <= b[ADDR_W-1:0];
                    CLS_CTRL: begin
                        dctl.on  <= b[3];
                        dctl.dim <= b[2:0];
                    end
                    default: ;
                endcase
            end else if (write_ok) begin
                ram_we    <= 1'b1;
                ram_addr  <= cur_addr;
                ram_wdata <= b;
                if (!dcfg.fixed_addr) cur_addr <= cur_addr + 1'b1;
            end
        end
    end

    AST_WE_ADDR_VALID: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (32'(ram_addr) < RAM_BYTES)); // R11
    AST_MODE_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        (disp_mode != $past(disp_mode)) |-> !dctl.on); // R4
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cur_addr == (dcfg.fixed_addr ? ram_addr : ram_addr + 1'b1))); // R10
    AST_NO_WRITE_OTHER_SEL: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (dcfg.wr_sel == WSEL_RAM)); // R12

endmodule

// File: rtl/segrx_top.sv
module segrx_top
    import segrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_stb,
    input  logic        ser_clk,
    input  logic        ser_din,
    output logic [1:0]  disp_mode,
    output logic        test_mode,
    output logic        fixed_addr,
    output logic [1:0]  wr_sel,
    output logic [3:0]  cur_addr,
    output logic        disp_on,
    output logic [2:0]  dim_code,
    output logic        ram_we,
    output logic [3:0]  ram_addr,
    output logic [7:0]  ram_wdata
);
    localparam int          IDX_STB = 0;
    localparam int          IDX_CLK = 1;
    localparam int          IDX_DIN = 2;
    localparam logic [2:0]  SYNC_RST = 3'b001;

    logic [2:0] s_in, s_out, s_rise;
    rx_byte_t   rx_byte;
    logic       rx_vld;
    data_cfg_t  dcfg;
    disp_ctrl_t dctl;

    assign s_in = {ser_din, ser_clk, ser_stb};

    segrx_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(SYNC_RST)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (s_in),
        .sync_out (s_out),
        .rise     (s_rise)
    );

    segrx_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .stb_hi    (s_out[IDX_STB]),
        .sclk_rise (s_rise[IDX_CLK]),
        .din       (s_out[IDX_DIN]),
        .rx_byte   (rx_byte),
        .rx_vld    (rx_vld)
    );

    segrx_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .rx_vld    (rx_vld),
        .rx_byte   (rx_byte),
        .disp_mode (disp_mode),
        .dcfg      (dcfg),
        .cur_addr  (cur_addr),
        .dctl      (dctl),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    assign test_mode  = dcfg.test_mode;
    assign fixed_addr = dcfg.fixed_addr;
    assign wr_sel     = dcfg.wr_sel;
    assign disp_on    = dctl.on;
    assign dim_code   = dctl.dim;

endmodule

// File: tb/segrx_top_tb_top.sv
module segrx_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_stb = 1'b1;
    logic ser_clk = 1'b1;
    logic ser_din = 1'b0;

    logic [1:0] disp_mode;
    logic       test_mode, fixed_addr, disp_on, ram_we;
    logic [1:0] wr_sel;
    logic [3:0] cur_addr, ram_addr;
    logic [2:0] dim_code;
    logic [7:0] ram_wdata;

    segrx_top dut_i (
        .clk(clk), .rst(rst), .ser_stb(ser_stb), .ser_clk(ser_clk), .ser_din(ser_din),
        .disp_mode(disp_mode), .test_mode(test_mode), .fixed_addr(fixed_addr),
        .wr_sel(wr_sel), .cur_addr(cur_addr), .disp_on(disp_on), .dim_code(dim_code),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    always #5 clk = ~clk;

    // behavioural reference state, R8 reset values
    int         m_mode = 3, m_addr = 0, m_wsel = 0, m_dim = 0;
    bit         m_fixed = 0, m_test = 0, m_on = 0;
    bit         e_we = 0;
    int         e_ra = 0, e_wd = 0;
    int         vectors = 0, fails = 0;
    bit         done = 0;
    logic [7:0] fq [$];

    task automatic chk(input string req, input string name, input int got, input int exp);
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, name, got, exp, $time);
        end
    endtask

    task automatic compare();
        vectors++;
        chk("R4", "disp_mode", int'(disp_mode), m_mode);
        chk("R5", "test_mode", int'(test_mode), int'(m_test));
        chk("R10", "fixed_addr", int'(fixed_addr), int'(m_fixed));
        chk("R5", "wr_sel", int'(wr_sel), m_wsel);
        chk("R6", "cur_addr", int'(cur_addr), m_addr);
        chk("R7", "disp_on", int'(disp_on), int'(m_on));
        chk("R7", "dim_code", int'(dim_code), m_dim);
        chk("R9", "ram_we", int'(ram_we), int'(e_we));
        if (e_we) begin
            chk("R9", "ram_addr", int'(ram_addr), e_ra);
            chk("R9", "ram_wdata", int'(ram_wdata), e_wd);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    // R3: command class from the top two bits
    task automatic model_byte(input logic [7:0] b, input bit first);
        if (first) begin
            if (b[7:6] == 2'b00) begin
                if (int'(b[1:0]) != m_mode) begin m_mode = int'(b[1:0]); m_on = 0; end
            end else if (b[7:6] == 2'b01) begin
                m_test = b[3]; m_fixed = b[2]; m_wsel = int'(b[1:0]);
            end else if (b[7:6] == 2'b11) begin
                m_addr = int'(b[3:0]);
            end else begin
                m_dim = int'(b[2:0]); m_on = b[3];
            end
        end else if (m_wsel == 0 && m_addr < 14) begin
            e_we = 1; e_ra = m_addr; e_wd = int'(b);
            if (!m_fixed) m_addr = m_addr + 1;
        end
    endtask

    // R1: LSB first on rising serial clock; R9: four-edge latency
    task automatic send_bit(input logic b, input bit last, input logic [7:0] full, input bit first);
        ser_clk = 1'b0; ser_din = b;
        repeat (4) tick();
        ser_clk = 1'b1;
        repeat (3) tick();
        if (last) model_byte(full, first);
        tick();
        e_we = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit first);
        for (int i = 0; i < 8; i++) send_bit(b[i], i == 7, b, first);
    endtask

    task automatic send_frame(input logic [7:0] q [$]);
        ser_stb = 1'b0;
        repeat (4) tick();
        foreach (q[i]) send_byte(q[i], i == 0);
        repeat (2) tick();
        ser_stb = 1'b1;
        repeat (4) tick();
    endtask

    initial begin
        @(negedge clk);
        repeat (3) tick();               // R8 reset state
        rst = 1'b0;
        repeat (4) tick();               // R8 after release

        fq = '{8'h8B}; send_frame(fq);   // R7 on, dim 3
        fq = '{8'h02}; send_frame(fq);   // R4 new mode forces off
        fq = '{8'h8F}; send_frame(fq);   // R7
        fq = '{8'h3E}; send_frame(fq);   // R4 same mode, don't-care bits: no change
        fq = '{8'h40}; send_frame(fq);   // R5 increment mode
        fq = '{8'hF2, 8'h11, 8'h22, 8'h33}; send_frame(fq); // R6 R9 R10
        fq = '{8'h44}; send_frame(fq);   // R10 fixed
        fq = '{8'hC5, 8'hA5, 8'h5A}; send_frame(fq);        // R10 fixed address writes
        fq = '{8'h40}; send_frame(fq);
        fq = '{8'hCC, 8'h01, 8'h02, 8'h03}; send_frame(fq); // R11 0x0D -> 0x0E then dropped
        fq = '{8'h40, 8'h77}; send_frame(fq);               // R11 still out of range
        fq = '{8'hCF, 8'h66}; send_frame(fq);               // R11 0x0F
        fq = '{8'hC3, 8'h99}; send_frame(fq);               // R11 recovery
        fq = '{8'h7A}; send_frame(fq);   // R5 test, sel 10, bits 5:4 ignored
        fq = '{8'hC1, 8'h55, 8'hAA}; send_frame(fq);        // R12 no writes
        fq = '{8'h40}; send_frame(fq);

        // R2: abort after three bits, next frame starts with a command
        ser_stb = 1'b0;
        repeat (4) tick();
        send_bit(1'b0, 0, 8'h00, 0);
        send_bit(1'b0, 0, 8'h00, 0);
        send_bit(1'b1, 0, 8'h00, 0);
        ser_stb = 1'b1;
        repeat (4) tick();
        fq = '{8'h89, 8'h12}; send_frame(fq);               // R2 R7 R9

        // R1: serial clock toggling with strobe high has no effect
        for (int k = 0; k < 20; k++) begin
            ser_clk = ~ser_clk; ser_din = k[1];
            repeat (3) tick();
        end
        ser_clk = 1'b1;
        repeat (4) tick();
        fq = '{8'h01}; send_frame(fq);   // R4 mode change to 01
        fq = '{8'hB6}; send_frame(fq);   // R3 R7 bits 5:4 ignored

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule